// File: doc/BRIEF.md
# Dual-Host Clock Configuration Controller

This block stores the clock-tree settings of a chip that runs two processors, a primary host and a secondary host. It holds the PLL controls (enable, bypass, multiplier, output divider). It also holds three clock dividers: one for the clock-out monitor, one for the primary-subsystem clock and one for the ADC clock. A gate enable for the secondary-subsystem clock completes the set. This clock runs at the PLL system clock rate and has no divider. All these values drive the clock tree continuously.

Each host reaches the block through its own simple register port: read strobe, write strobe, 4-bit address, write data, privilege flag and combinational read data. Every register has a fixed owner. A lending semaphore lets the secondary host take over the PLL multiplier and output divider for a while, for example during flash programming. Divider writes that would drive a derived clock above its ceiling are refused. The ceiling is computed from a parameter that gives the PLL output frequency. A refused write of any kind leaves the register as it was and raises a sticky error flag for the host that issued it.

Top module: `clkcfg_dual_host`

## Requirements
- R1: After reset: clock-out monitor divider 4, primary-subsystem divider 4, ADC divider 8, secondary clock enable 1, PLL enable 0, PLL bypass 1, multiplier MULT_RST (10 by default), output divider 1, semaphore free, both error flags 0.
- R2: The primary host writes the control register (address 0: bit0 PLL enable, bit1 bypass), the monitor divider (address 3), the primary-subsystem divider (address 4) and the secondary clock enable (address 5, bit0) only when its privilege flag is 1. The same rule covers the multiplier (address 1) and output divider (address 2) while the semaphore is free.
- R3: A secondary-host write to a register owned by the primary host is refused. The secondary host may read every register, PLL fields included.
- R4: Only the secondary host may write the ADC divider (address 6), and it needs no privilege to do so. A primary-host write there is refused.
- R5: The semaphore sits at address 7. A secondary-host write of bit0 takes the semaphore (1) or releases it (0). The grant is given at once, and a read returns bit0 request and bit1 grant. A primary-host write to address 7 is refused.
- R6: While the secondary host holds the grant, it may write the multiplier and output divider, and the primary host's writes to them are refused. Without the grant, the secondary host's writes to them are refused.
- R7: A divider value d is accepted for the primary-subsystem divider only if d ≥ ceil(SYS_KHZ/PSUB_MAX_KHZ) (2 by default, for 150000/100000 kHz). It is accepted for the ADC divider only if d ≥ ceil(SYS_KHZ/ADC_MAX_KHZ) (4 by default, for 150000/37500 kHz). Zero is always refused.
- R8: A refused write leaves every register unchanged and sets that host's sticky error flag, read at address 8 bit0. The flag stays set through later accepted writes until the host writes 1 to address 8 bit0. A write to an unmapped address is refused, and reading an unmapped address returns 0.
- R9: When both hosts write the same register in one cycle, the value from the host that holds the right is stored, and the other host's error flag is set.
- R10: The output ports always carry the stored register values, and sec_clk_en gates the secondary-subsystem clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| p_rd | input | 1 | Primary host read strobe |
| p_wr | input | 1 | Primary host write strobe |
| p_priv | input | 1 | Primary host privileged access |
| p_addr | input | 4 | Primary host register address |
| p_wdata | input | DATA_W | Primary host write data |
| p_rdata | output | DATA_W | Primary host read data (0 when no read) |
| s_rd | input | 1 | Secondary host read strobe |
| s_wr | input | 1 | Secondary host write strobe |
| s_priv | input | 1 | Secondary host privileged access |
| s_addr | input | 4 | Secondary host register address |
| s_wdata | input | DATA_W | Secondary host write data |
| s_rdata | output | DATA_W | Secondary host read data (0 when no read) |
| pll_en | output | 1 | PLL on |
| pll_bypass | output | 1 | PLL bypass |
| pll_mult | output | MULT_W | PLL multiplier |
| pll_odiv | output | ODIV_W | PLL output divider |
| mon_div | output | DIV_W | Clock-out monitor divider |
| psub_div | output | DIV_W | Primary-subsystem clock divider |
| sec_clk_en | output | 1 | Secondary-subsystem clock enable |
| adc_div | output | DIV_W | ADC clock divider |

## Verification
The bench targets the divider ceilings at their edges: a value one below the minimum, the minimum itself, and zero. A design that checked the ceiling with the wrong rounding, or that let zero through, would store a divider that overclocks the subsystem. The bench also hands the semaphore over and back while both hosts write the multiplier in the same cycle. A design that decided ownership by a fixed priority instead of by the grant would store the wrong value or flag the wrong host. Further cases cover unprivileged primary writes, secondary writes to primary-owned registers and primary writes to the ADC divider. A design that gated on the wrong condition would change a register that must stay put, or leave the error flag clear. The bench also checks that the error flag stays set through a later accepted write.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

   localparam int unsigned AW = 4;

   typedef enum logic [AW-1:0] {
      RA_PLLCTL = 4'd0,
      RA_MULT   = 4'd1,
      RA_ODIV   = 4'd2,
      RA_MON    = 4'd3,
      RA_PSUB   = 4'd4,
      RA_SECEN  = 4'd5,
      RA_ADC    = 4'd6,
      RA_SEMA   = 4'd7,
      RA_ERR    = 4'd8
   } reg_addr_e;

   typedef enum logic {
      HOST_PRI = 1'b0,
      HOST_SEC = 1'b1
   } host_e;

endpackage

// File: rtl/clkcfg_div_limit.sv
module clkcfg_div_limit #(
   parameter int unsigned SRC_KHZ = 150000,
   parameter int unsigned MAX_KHZ = 100000,
   parameter int unsigned DIV_W   = 6
) (
   input  logic [DIV_W-1:0] div,
   output logic             ok
);

   generate
      if (MAX_KHZ == 0) begin : g_free
         assign ok = |div;
      end else begin : g_cap
         localparam int unsigned MIN_DIV = (SRC_KHZ + MAX_KHZ - 1) / MAX_KHZ;
         localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);
         if (MIN_DIV >= (1 << DIV_W)) begin : g_bad
            $error("clkcfg_div_limit: DIV_W cannot hold the minimum divider");
         end
         assign ok = (|div) && (div >= MIN_V);
      end
   endgenerate

endmodule

// File: rtl/clkcfg_perm.sv
module clkcfg_perm
   import clkcfg_pkg::*;
#(
   parameter host_e HOST = HOST_PRI
) (
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic          priv,
   input  logic          held,
   input  logic          lim_ok,
   output logic          allow,
   output logic          deny
);

   logic may;

   generate
      if (HOST == HOST_PRI) begin : g_pri
         always_comb begin
            case (addr)
               RA_PLLCTL, RA_MON, RA_SECEN: may = priv;
               RA_MULT, RA_ODIV:            may = priv & ~held;
               RA_PSUB:                     may = priv & lim_ok;
               RA_ERR:                      may = 1'b1;
               default:                     may = 1'b0;
            endcase
         end
      end else begin : g_sec
         logic unused_priv;
         assign unused_priv = priv;
         always_comb begin
            case (addr)
               RA_MULT, RA_ODIV: may = held;
               RA_ADC:           may = lim_ok;
               RA_SEMA, RA_ERR:  may = 1'b1;
               default:          may = 1'b0;
            endcase
         end
      end
   endgenerate

   assign allow = wr & may;
   assign deny  = wr & ~may;

endmodule

// File: rtl/clkcfg_rd_mux.sv
module clkcfg_rd_mux
   import clkcfg_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned MULT_W = 7,
   parameter int unsigned ODIV_W = 3,
   parameter int unsigned DIV_W  = 6
) (
   input  logic              rd,
   input  logic [AW-1:0]     addr,
   input  logic              pll_en,
   input  logic              pll_bypass,
   input  logic [MULT_W-1:0] mult,
   input  logic [ODIV_W-1:0] odiv,
   input  logic [DIV_W-1:0]  mon,
   input  logic [DIV_W-1:0]  psub,
   input  logic              sec_en,
   input  logic [DIV_W-1:0]  adc,
   input  logic              held,
   input  logic              err_own,
   output logic [DATA_W-1:0] rdata
);

   always_comb begin
      rdata = '0;
      if (rd) begin
         case (addr)
            RA_PLLCTL: rdata[1:0]        = {pll_bypass, pll_en};
            RA_MULT:   rdata[MULT_W-1:0] = mult;
            RA_ODIV:   rdata[ODIV_W-1:0] = odiv;
            RA_MON:    rdata[DIV_W-1:0]  = mon;
            RA_PSUB:   rdata[DIV_W-1:0]  = psub;
            RA_SECEN:  rdata[0]          = sec_en;
            RA_ADC:    rdata[DIV_W-1:0]  = adc;
            RA_SEMA:   rdata[1:0]        = {held, held};
            RA_ERR:    rdata[0]          = err_own;
            default:   rdata             = '0;
         endcase
      end
   end

endmodule

// File: rtl/clkcfg_dual_host.sv
module clkcfg_dual_host
   import clkcfg_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned MULT_W       = 7,
   parameter int unsigned ODIV_W       = 3,
   parameter int unsigned DIV_W        = 6,
   parameter int unsigned SYS_KHZ      = 150000,
   parameter int unsigned PSUB_MAX_KHZ = 100000,
   parameter int unsigned ADC_MAX_KHZ  = 37500,
   parameter int unsigned MULT_RST     = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p_rd,
   input  logic              p_wr,
   input  logic              p_priv,
   input  logic [AW-1:0]     p_addr,
   input  logic [DATA_W-1:0] p_wdata,
   output logic [DATA_W-1:0] p_rdata,
   input  logic              s_rd,
   input  logic              s_wr,
   input  logic              s_priv,
   input  logic [AW-1:0]     s_addr,
   input  logic [DATA_W-1:0] s_wdata,
   output logic [DATA_W-1:0] s_rdata,
   output logic              pll_en,
   output logic              pll_bypass,
   output logic [MULT_W-1:0] pll_mult,
   output logic [ODIV_W-1:0] pll_odiv,
   output logic [DIV_W-1:0]  mon_div,
   output logic [DIV_W-1:0]  psub_div,
   output logic              sec_clk_en,
   output logic [DIV_W-1:0]  adc_div
);

   localparam int unsigned NH       = 2;
   localparam int unsigned PSUB_MIN = (SYS_KHZ + PSUB_MAX_KHZ - 1) / PSUB_MAX_KHZ;

   generate
      if (DIV_W < 4) begin : g_chk_div
         $error("clkcfg_dual_host: DIV_W must hold the reset value 8");
      end
      if (DATA_W < MULT_W || DATA_W < DIV_W || DATA_W < ODIV_W || DATA_W < 2) begin : g_chk_data
         $error("clkcfg_dual_host: DATA_W narrower than a field");
      end
      if (MULT_RST >= (1 << MULT_W)) begin : g_chk_mult
         $error("clkcfg_dual_host: MULT_RST does not fit MULT_W");
      end
   endgenerate

   logic              en_q, byp_q, secen_q, held_q;
   logic [MULT_W-1:0] mult_q;
   logic [ODIV_W-1:0] odiv_q;
   logic [DIV_W-1:0]  mon_q, psub_q, adc_q;

   logic              wr_a    [NH];
   logic              rd_a    [NH];
   logic              priv_a  [NH];
   logic [AW-1:0]     addr_a  [NH];
   logic [DATA_W-1:0] wdata_a [NH];
   logic [DATA_W-1:0] rdata_a [NH];
   logic              lim_a   [NH];
   logic              allow_a [NH];
   logic              deny_a  [NH];
   logic              err_q   [NH];

   assign wr_a[0] = p_wr;    assign wr_a[1] = s_wr;
   assign rd_a[0] = p_rd;    assign rd_a[1] = s_rd;
   assign priv_a[0] = p_priv;  assign priv_a[1] = s_priv;
   assign addr_a[0] = p_addr;  assign addr_a[1] = s_addr;
   assign wdata_a[0] = p_wdata; assign wdata_a[1] = s_wdata;
   assign p_rdata = rdata_a[0];
   assign s_rdata = rdata_a[1];

   clkcfg_div_limit #(.SRC_KHZ(SYS_KHZ), .MAX_KHZ(PSUB_MAX_KHZ), .DIV_W(DIV_W)) u_lim_psub (
      .div (p_wdata[DIV_W-1:0]),
      .ok  (lim_a[0])
   );

   clkcfg_div_limit #(.SRC_KHZ(SYS_KHZ), .MAX_KHZ(ADC_MAX_KHZ), .DIV_W(DIV_W)) u_lim_adc (
      .div (s_wdata[DIV_W-1:0]),
      .ok  (lim_a[1])
   );

   generate
      for (genvar h = 0; h < NH; h++) begin : g_host
         clkcfg_perm #(.HOST(host_e'(h))) u_perm (
            .wr     (wr_a[h]),
            .addr   (addr_a[h]),
            .priv   (priv_a[h]),
            .held   (held_q),
            .lim_ok (lim_a[h]),
            .allow  (allow_a[h]),
            .deny   (deny_a[h])
         );

         clkcfg_rd_mux #(.DATA_W(DATA_W), .MULT_W(MULT_W), .ODIV_W(ODIV_W), .DIV_W(DIV_W)) u_rd (
            .rd         (rd_a[h]),
            .addr       (addr_a[h]),
            .pll_en     (en_q),
            .pll_bypass (byp_q),
            .mult       (mult_q),
            .odiv       (odiv_q),
            .mon        (mon_q),
            .psub       (psub_q),
            .sec_en     (secen_q),
            .adc        (adc_q),
            .held       (held_q),
            .err_own    (err_q[h]),
            .rdata      (rdata_a[h])
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               err_q[h] <= 1'b0;
            else if (deny_a[h])
               err_q[h] <= 1'b1;
            else if (allow_a[h] && addr_a[h] == RA_ERR && wdata_a[h][0])
               err_q[h] <= 1'b0;
         end
      end
   endgenerate

   logic p_we_ctl, p_we_mult, p_we_odiv, p_we_mon, p_we_psub, p_we_secen;
   logic s_we_mult, s_we_odiv, s_we_adc, s_we_sema;

   assign p_we_ctl   = allow_a[0] && p_addr == RA_PLLCTL;
   assign p_we_mult  = allow_a[0] && p_addr == RA_MULT;
   assign p_we_odiv  = allow_a[0] && p_addr == RA_ODIV;
   assign p_we_mon   = allow_a[0] && p_addr == RA_MON;
   assign p_we_psub  = allow_a[0] && p_addr == RA_PSUB;
   assign p_we_secen = allow_a[0] && p_addr == RA_SECEN;
   assign s_we_mult  = allow_a[1] && s_addr == RA_MULT;
   assign s_we_odiv  = allow_a[1] && s_addr == RA_ODIV;
   assign s_we_adc   = allow_a[1] && s_addr == RA_ADC;
   assign s_we_sema  = allow_a[1] && s_addr == RA_SEMA;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         byp_q   <= 1'b1;
         mult_q  <= MULT_W'(MULT_RST);
         odiv_q  <= ODIV_W'(1);
         mon_q   <= DIV_W'(4);
         psub_q  <= DIV_W'(4);
         secen_q <= 1'b1;
         adc_q   <= DIV_W'(8);
         held_q  <= 1'b0;
      end else begin
         if (p_we_ctl) begin
            en_q  <= p_wdata[0];
            byp_q <= p_wdata[1];
         end
         if (s_we_mult)      mult_q <= s_wdata[MULT_W-1:0];
         else if (p_we_mult) mult_q <= p_wdata[MULT_W-1:0];
         if (s_we_odiv)      odiv_q <= s_wdata[ODIV_W-1:0];
         else if (p_we_odiv) odiv_q <= p_wdata[ODIV_W-1:0];
         if (p_we_mon)   mon_q   <= p_wdata[DIV_W-1:0];
         if (p_we_psub)  psub_q  <= p_wdata[DIV_W-1:0];
         if (p_we_secen) secen_q <= p_wdata[0];
         if (s_we_adc)   adc_q   <= s_wdata[DIV_W-1:0];
         if (s_we_sema)  held_q  <= s_wdata[0];
      end
   end

   assign pll_en     = en_q;
   assign pll_bypass = byp_q;
   assign pll_mult   = mult_q;
   assign pll_odiv   = odiv_q;
   assign mon_div    = mon_q;
   assign psub_div   = psub_q;
   assign sec_clk_en = secen_q;
   assign adc_div    = adc_q;

   logic unused_wdata;
   assign unused_wdata = ^{p_wdata, s_wdata};

   AST_PRIV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      p_wr && !p_priv && p_addr == RA_MON |=> $stable(mon_div)); // R2

   AST_SEC_NO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      s_wr && s_addr == RA_PLLCTL && !(p_wr && p_addr == RA_PLLCTL)
      |=> $stable(pll_en) && $stable(pll_bypass)); // R3

   AST_ADC_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(s_wr) && $past(s_addr) == RA_ADC) |-> $stable(adc_div)); // R4

   AST_LENT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      held_q && p_wr && p_addr == RA_MULT && !(s_wr && s_addr == RA_MULT)
      |=> $stable(pll_mult)); // R6

   AST_PSUB_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      psub_div != '0 && int'(psub_div) >= int'(PSUB_MIN)); // R7

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q[0] && !(p_wr && p_addr == RA_ERR) |=> err_q[0]); // R8

   AST_DENY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      s_wr && s_addr == RA_MON |=> err_q[1]); // R8

endmodule

// File: tb/clkcfg_dual_host_tb.sv
module clkcfg_dual_host_tb;

   localparam int unsigned NV = 22;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        p_rd = 0, p_wr = 0, p_priv = 0;
   logic [3:0]  p_addr = 0;
   logic [15:0] p_wdata = 0;
   logic [15:0] p_rdata;
   logic        s_rd = 0, s_wr = 0, s_priv = 0;
   logic [3:0]  s_addr = 0;
   logic [15:0] s_wdata = 0;
   logic [15:0] s_rdata;
   logic        pll_en, pll_bypass, sec_clk_en;
   logic [6:0]  pll_mult;
   logic [2:0]  pll_odiv;
   logic [5:0]  mon_div, psub_div, adc_div;

   int checks = 0;
   int errors = 0;
   logic [15:0] v;

   always #5 clk = ~clk;

   clkcfg_dual_host u_dut (
      .clk(clk), .rst_n(rst_n),
      .p_rd(p_rd), .p_wr(p_wr), .p_priv(p_priv), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
      .s_rd(s_rd), .s_wr(s_wr), .s_priv(s_priv), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
      .pll_en(pll_en), .pll_bypass(pll_bypass), .pll_mult(pll_mult), .pll_odiv(pll_odiv),
      .mon_div(mon_div), .psub_div(psub_div), .sec_clk_en(sec_clk_en), .adc_div(adc_div)
   );

   // {host(0=primary,1=secondary), priv, addr, wdata, expected read-back, expected error flag}
   localparam logic [38:0] VEC [NV] = '{
      {1'b0, 1'b1, 4'd3, 16'd6,  16'd6,  1'b0},  // R2 privileged monitor write
      {1'b0, 1'b0, 4'd3, 16'd9,  16'd6,  1'b1},  // R2 unprivileged refused
      {1'b1, 1'b1, 4'd3, 16'd3,  16'd6,  1'b1},  // R3 secondary on primary reg
      {1'b0, 1'b1, 4'd4, 16'd1,  16'd4,  1'b1},  // R7 below floor
      {1'b0, 1'b1, 4'd4, 16'd2,  16'd2,  1'b0},  // R7 at floor
      {1'b0, 1'b1, 4'd4, 16'd0,  16'd2,  1'b1},  // R7 zero
      {1'b1, 1'b0, 4'd6, 16'd3,  16'd8,  1'b1},  // R7 adc below floor
      {1'b1, 1'b0, 4'd6, 16'd4,  16'd4,  1'b0},  // R4 adc by secondary
      {1'b0, 1'b1, 4'd6, 16'd10, 16'd4,  1'b1},  // R4 adc by primary refused
      {1'b1, 1'b0, 4'd1, 16'd20, 16'd10, 1'b1},  // R6 no grant
      {1'b0, 1'b1, 4'd1, 16'd30, 16'd30, 1'b0},  // R2 mult while free
      {1'b1, 1'b0, 4'd7, 16'd1,  16'd3,  1'b0},  // R5 take semaphore
      {1'b0, 1'b1, 4'd1, 16'd40, 16'd30, 1'b1},  // R6 primary blocked
      {1'b1, 1'b0, 4'd1, 16'd50, 16'd50, 1'b0},  // R6 lent mult
      {1'b1, 1'b0, 4'd2, 16'd5,  16'd5,  1'b0},  // R6 lent odiv
      {1'b1, 1'b0, 4'd7, 16'd0,  16'd0,  1'b0},  // R5 release
      {1'b1, 1'b0, 4'd1, 16'd60, 16'd50, 1'b1},  // R6 after release
      {1'b0, 1'b1, 4'd0, 16'd3,  16'd3,  1'b0},  // R2 pll control
      {1'b1, 1'b1, 4'd0, 16'd0,  16'd3,  1'b1},  // R3 secondary reads control
      {1'b0, 1'b1, 4'd5, 16'd0,  16'd0,  1'b0},  // R2 gate secondary clock
      {1'b0, 1'b1, 4'd15, 16'd7, 16'd0,  1'b1},  // R8 unmapped
      {1'b0, 1'b1, 4'd7, 16'd1,  16'd0,  1'b1}   // R5 primary on semaphore
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic h, input logic pv, input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      if (h) begin s_wr = 1; s_priv = pv; s_addr = a; s_wdata = d; end
      else   begin p_wr = 1; p_priv = pv; p_addr = a; p_wdata = d; end
      @(negedge clk);
      p_wr = 0; s_wr = 0;
   endtask

   task automatic wr_both(input logic [3:0] a, input logic [15:0] dp, input logic [15:0] ds);
      @(negedge clk);
      p_wr = 1; p_priv = 1; p_addr = a; p_wdata = dp;
      s_wr = 1; s_priv = 0; s_addr = a; s_wdata = ds;
      @(negedge clk);
      p_wr = 0; s_wr = 0;
   endtask

   task automatic rd(input logic h, input logic [3:0] a, output logic [15:0] d);
      if (h) begin s_rd = 1; s_addr = a; end
      else   begin p_rd = 1; p_addr = a; end
      #1;
      d = h ? s_rdata : p_rdata;
      p_rd = 0; s_rd = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      #1;
      chk("R1 mon_div", 16'(mon_div), 16'd4);
      chk("R1 psub_div", 16'(psub_div), 16'd4);
      chk("R1 adc_div", 16'(adc_div), 16'd8);
      chk("R1 sec_clk_en", 16'(sec_clk_en), 16'd1);
      chk("R1 pll_en", 16'(pll_en), 16'd0);
      chk("R1 pll_bypass", 16'(pll_bypass), 16'd1);
      chk("R1 pll_mult", 16'(pll_mult), 16'd10);
      chk("R1 pll_odiv", 16'(pll_odiv), 16'd1);
      rd(1'b1, 4'd7, v); chk("R1 semaphore", v, 16'd0);
      rd(1'b0, 4'd8, v); chk("R1 err primary", v, 16'd0);

      for (int i = 0; i < NV; i++) begin
         logic        h, pv, ee;
         logic [3:0]  a;
         logic [15:0] d, ex;
         {h, pv, a, d, ex, ee} = VEC[i];
         wr(h, pv, a, d);
         rd(h, a, v);
         chk($sformatf("vec %0d value (R2-R8 table)", i), v, ex);
         rd(h, 4'd8, v);
         chk($sformatf("vec %0d R8 error flag", i), v, 16'(ee));
         wr(h, 1'b0, 4'd8, 16'd1);
      end

      // R10 outputs follow stored values
      #1;
      chk("R10 pll_en", 16'(pll_en), 16'd1);
      chk("R10 pll_bypass", 16'(pll_bypass), 16'd1);
      chk("R10 pll_mult", 16'(pll_mult), 16'd50);
      chk("R10 pll_odiv", 16'(pll_odiv), 16'd5);
      chk("R10 psub_div", 16'(psub_div), 16'd2);
      chk("R10 adc_div", 16'(adc_div), 16'd4);
      chk("R10 sec_clk_en", 16'(sec_clk_en), 16'd0);

      // R8 sticky across a later accepted write
      wr(1'b0, 1'b0, 4'd3, 16'd9);
      wr(1'b0, 1'b1, 4'd3, 16'd5);
      rd(1'b0, 4'd8, v); chk("R8 sticky after good write", v, 16'd1);
      chk("R8 good write applied", 16'(mon_div), 16'd5);
      wr(1'b0, 1'b0, 4'd8, 16'd1);
      rd(1'b0, 4'd8, v); chk("R8 cleared", v, 16'd0);

      // R9 same-cycle writes while secondary holds the grant
      wr(1'b1, 1'b0, 4'd7, 16'd1);
      wr_both(4'd1, 16'd70, 16'd71);
      #1;
      chk("R9 holder wins mult", 16'(pll_mult), 16'd71);
      rd(1'b0, 4'd8, v); chk("R9 primary flagged", v, 16'd1);
      rd(1'b1, 4'd8, v); chk("R9 secondary clean", v, 16'd0);
      wr(1'b0, 1'b0, 4'd8, 16'd1);

      // R9 same-cycle writes after release
      wr(1'b1, 1'b0, 4'd7, 16'd0);
      wr_both(4'd1, 16'd72, 16'd73);
      #1;
      chk("R9 owner wins mult", 16'(pll_mult), 16'd72);
      rd(1'b1, 4'd8, v); chk("R9 secondary flagged", v, 16'd1);
      rd(1'b0, 4'd8, v); chk("R9 primary clean", v, 16'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule